// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches recent virtual-to-physical page translations for a processor's memory pipeline. A lookup presents a virtual page number together with the address-space ID of the running process. In the same cycle the block returns either a hit, with the physical frame number, the permission bits and the entry's global flag, or a miss, which asks the page walker to fetch the mapping. When the walker finishes, it installs its result through a refill port.

Every entry records the address-space ID that was current when it was filled, so translations for several processes can be held at the same time. An entry marked global serves every address space. Kernel mappings use this flag, and a flush aimed at one address space does not remove them. Software manages the contents through an invalidation port. One command empties the whole cache, one removes the entries of a single address space, and one removes the mapping of a single page. A context-switch strobe empties all non-global entries, but only while address-space tagging is switched off.

The storage holds 64 entries as 16 sets of 4 ways. Within a set, a new entry goes into an empty way if there is one. Otherwise a round-robin pointer kept for that set chooses the way to replace.

Top module: `asid_tlb`

## Requirements
- R1: The lookup result is combinational from the stored state. With `lk_valid` high, exactly one of `lk_hit` and `lk_walk` is high in the same cycle. On a hit, `lk_pfn`, `lk_perm` and `lk_global` carry the matching entry's fields. With `lk_valid` low, both flags are low.
- R2: Capacity is 64 entries in 16 sets of 4 ways, and the set is chosen by `vpn[3:0]`. Filling a fifth distinct page into a full set evicts one entry of that set only, and entries in other sets remain.
- R3: A non-global entry hits only when its stored address-space ID equals `lk_asid` and its page matches.
- R4: An entry filled with `fill_global` high hits for any `lk_asid`.
- R5: An invalidate with `inv_cmd` = 2'b01 removes every non-global entry whose ID equals `inv_asid`. Global entries stay, and so do entries of other IDs.
- R6: When `ctx_switch` is high and `tag_en` is low, every non-global entry is removed. When `tag_en` is high, `ctx_switch` has no effect.
- R7: An invalidate with `inv_cmd` = 2'b10 removes only the entries that would hit for page `inv_vpn` under ID `inv_asid`. Other IDs' entries for the same page stay.
- R8: An invalidate with `inv_cmd` = 2'b00 removes all entries, global ones included. Code 2'b11 removes nothing.
- R9: A refill that matches no existing entry goes to the lowest-numbered invalid way of its set. If the set is full, it goes to the way named by that set's round-robin pointer, which starts at 0 after reset and advances by one after each such eviction.
- R10: A refill whose page and ID already hit overwrites that entry in place, so no duplicate is created. A lookup in the next cycle returns the new frame.
- R11: An invalidate or flushing context switch changes the state at the clock edge that accepts it, so a lookup in the same cycle sees the old contents. A refill presented in a cycle with `inv_valid` high or a flushing context switch is dropped.
- R12: After a synchronous reset, all entries are invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tag_en | input | 1 | Address-space tagging enabled |
| ctx_switch | input | 1 | Context-switch strobe |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Current address-space ID |
| lk_hit | output | 1 | Translation found |
| lk_walk | output | 1 | Miss: page walk needed |
| lk_pfn | output | 20 | Physical frame on hit |
| lk_perm | output | 4 | Permission bits on hit |
| lk_global | output | 1 | Hit entry is global |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Refill virtual page |
| fill_asid | input | 8 | Refill address-space ID |
| fill_pfn | input | 20 | Refill frame number |
| fill_perm | input | 4 | Refill permission bits |
| fill_global | input | 1 | Refill entry is global |
| inv_valid | input | 1 | Invalidate request |
| inv_cmd | input | 2 | 00 all, 01 one ID, 10 one page, 11 none |
| inv_vpn | input | 20 | Page for the one-page invalidate |
| inv_asid | input | 8 | ID for the ID and page invalidates |

## Verification
Several properties are checked on every cycle. The hit and walk flags are mutually exclusive, and no lookup ever matches two ways. A refill is visible with its frame on the very next lookup. After a full flush no lookup hits, and after a per-ID flush or a flushing context switch the only possible hits are global entries. Only the bench's scenarios show the rest. These are the victim order (invalid way first, then round robin), the in-place overwrite on a repeated refill, the fact that a per-page invalidate spares other IDs, the same-cycle old-state lookup, and the dropped refill. Random traffic compared against a bench model covers their interaction.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W  = 20;
    parameter int PFN_W  = 20;
    parameter int ASID_W = 8;
    parameter int PERM_W = 4;
    parameter int WAYS   = 4;
    parameter int SETS   = 16;

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [TAG_W-1:0]  tag;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
    } entry_t;

    typedef entry_t [WAYS-1:0] set_t;

    typedef enum logic [1:0] {
        KILL_ALL   = 2'b00,
        KILL_SPACE = 2'b01,
        KILL_PAGE  = 2'b10,
        KILL_NONE  = 2'b11
    } kill_cmd_e;

    function automatic logic [IDX_W-1:0] set_of(logic [VPN_W-1:0] v);
        return v[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(logic [VPN_W-1:0] v);
        return v[VPN_W-1:IDX_W];
    endfunction

    function automatic logic entry_hits(entry_t e, logic [TAG_W-1:0] t,
                                        logic [ASID_W-1:0] a);
        return e.valid && (e.tag == t) && (e.glob || (e.asid == a));
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  set_t              ways,
    input  logic [TAG_W-1:0]  tag,
    input  logic [ASID_W-1:0] asid,
    output logic [WAYS-1:0]   hits,
    output logic              any,
    output logic [WAY_W-1:0]  way,
    output entry_t            sel
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hits[w] = entry_hits(ways[w], tag, asid);
    end

    assign any = |hits;

    // lowest matching way wins
    always_comb begin
        way = '0;
        sel = ways[0];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hits[w]) begin
                way = WAY_W'(w);
                sel = ways[w];
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic [WAYS-1:0]  valids,
    input  logic [WAY_W-1:0] rr,
    input  logic             hit_any,
    input  logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim,
    output logic             use_rr
);
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = rr;
        use_rr = 1'b1;
        if (hit_any) begin
            victim = hit_way;
            use_rr = 1'b0;
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (!found && !valids[w]) begin
                    victim = WAY_W'(w);
                    use_rr = 1'b0;
                    found  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tag_en,
    input  logic              ctx_switch,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_walk,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_perm,
    output logic              lk_global,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              fill_global,
    input  logic              inv_valid,
    input  logic [1:0]        inv_cmd,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid
);
    set_t             sets_q [SETS];
    logic [WAY_W-1:0] rr_q   [SETS];

    // ---------------- lookup ----------------
    logic [WAYS-1:0]  look_hits;
    logic             look_any;
    logic [WAY_W-1:0] look_way;
    entry_t           look_sel;

    tlb_match u_look (
        .ways (sets_q[set_of(lk_vpn)]),
        .tag  (tag_of(lk_vpn)),
        .asid (lk_asid),
        .hits (look_hits),
        .any  (look_any),
        .way  (look_way),
        .sel  (look_sel)
    );

    assign lk_hit    = lk_valid & look_any;
    assign lk_walk   = lk_valid & ~look_any;
    assign lk_pfn    = lk_hit ? look_sel.pfn  : '0;
    assign lk_perm   = lk_hit ? look_sel.perm : '0;
    assign lk_global = lk_hit & look_sel.glob;

    // ---------------- refill ----------------
    logic [IDX_W-1:0] fset;
    logic [WAYS-1:0]  fill_hits;
    logic [WAYS-1:0]  fill_valids;
    logic             fill_any;
    logic [WAY_W-1:0] fill_way;
    entry_t           fill_sel;
    logic [WAY_W-1:0] victim;
    logic             use_rr;
    entry_t           fill_entry;

    assign fset = set_of(fill_vpn);

    tlb_match u_fmatch (
        .ways (sets_q[fset]),
        .tag  (tag_of(fill_vpn)),
        .asid (fill_asid),
        .hits (fill_hits),
        .any  (fill_any),
        .way  (fill_way),
        .sel  (fill_sel)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_fv
        assign fill_valids[w] = sets_q[fset][w].valid;
    end

    tlb_victim u_vict (
        .valids  (fill_valids),
        .rr      (rr_q[fset]),
        .hit_any (fill_any),
        .hit_way (fill_way),
        .victim  (victim),
        .use_rr  (use_rr)
    );

    assign fill_entry = '{valid: 1'b1, glob: fill_global, asid: fill_asid,
                          tag: tag_of(fill_vpn), pfn: fill_pfn, perm: fill_perm};

    // ---------------- invalidation ----------------
    logic [IDX_W-1:0] pset;
    logic [WAYS-1:0]  page_hits;
    logic             page_any;
    logic [WAY_W-1:0] page_way;
    entry_t           page_sel;
    logic [WAYS-1:0]  kill [SETS];
    logic             flushing;
    logic             fill_go;

    assign pset = set_of(inv_vpn);

    tlb_match u_pmatch (
        .ways (sets_q[pset]),
        .tag  (tag_of(inv_vpn)),
        .asid (inv_asid),
        .hits (page_hits),
        .any  (page_any),
        .way  (page_way),
        .sel  (page_sel)
    );

    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                logic k;
                k = 1'b0;
                if (inv_valid) begin
                    case (kill_cmd_e'(inv_cmd))
                        KILL_ALL:   k = 1'b1;
                        KILL_SPACE: k = !sets_q[s][w].glob &&
                                        (sets_q[s][w].asid == inv_asid);
                        KILL_PAGE:  k = (IDX_W'(s) == pset) && page_hits[w];
                        default:    k = 1'b0;
                    endcase
                end
                if (ctx_switch && !tag_en && !sets_q[s][w].glob)
                    k = 1'b1;
                kill[s][w] = k;
            end
        end
    end

    assign flushing = inv_valid | (ctx_switch & ~tag_en);
    assign fill_go  = fill_valid & ~flushing;

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                sets_q[s] <= '0;
                rr_q[s]   <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    if (kill[s][w])
                        sets_q[s][w].valid <= 1'b0;
            if (fill_go) begin
                sets_q[fset][victim] <= fill_entry;
                if (use_rr)
                    rr_q[fset] <= rr_q[fset] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk
    import tlb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tag_en,
    input logic              ctx_switch,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic              lk_walk,
    input logic [PFN_W-1:0]  lk_pfn,
    input logic              lk_global,
    input logic              fill_valid,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [ASID_W-1:0] fill_asid,
    input logic [PFN_W-1:0]  fill_pfn,
    input logic              inv_valid,
    input logic [1:0]        inv_cmd,
    input logic [ASID_W-1:0] inv_asid,
    input logic [WAYS-1:0]   look_hits
);
    logic fill_ok;
    assign fill_ok = fill_valid && !inv_valid && !(ctx_switch && !tag_en);

    // R1
    hit_walk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> (lk_hit != lk_walk));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_walk));

    // R3
    single_way_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_hits));

    // R10
    refill_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && $past(fill_ok) && lk_vpn == $past(fill_vpn) &&
         lk_asid == $past(fill_asid)) |-> (lk_hit && lk_pfn == $past(fill_pfn)));

    // R8
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && $past(inv_valid && inv_cmd == 2'b00)) |-> !lk_hit);

    // R5
    space_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && $past(inv_valid && inv_cmd == 2'b01) &&
         lk_asid == $past(inv_asid)) |-> lk_global);

    // R6
    ctx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && $past(ctx_switch && !tag_en)) |-> lk_global);
endmodule

bind asid_tlb asid_tlb_chk u_chk (.*);

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;
    logic        clk = 0, rst = 1, tag_en = 1, ctx_switch = 0;
    logic        lk_valid = 0;
    logic [19:0] lk_vpn = 0;
    logic [7:0]  lk_asid = 0;
    logic        lk_hit, lk_walk, lk_global;
    logic [19:0] lk_pfn;
    logic [3:0]  lk_perm;
    logic        fill_valid = 0, fill_global = 0;
    logic [19:0] fill_vpn = 0, fill_pfn = 0;
    logic [7:0]  fill_asid = 0;
    logic [3:0]  fill_perm = 0;
    logic        inv_valid = 0;
    logic [1:0]  inv_cmd = 0;
    logic [19:0] inv_vpn = 0;
    logic [7:0]  inv_asid = 0;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    asid_tlb u_asid_tlb (.*);

    // reference model
    bit        mv [16][4];
    bit        mg [16][4];
    bit [7:0]  ma [16][4];
    bit [15:0] mt [16][4];
    bit [19:0] mp [16][4];
    bit [3:0]  mq [16][4];
    int        mrr [16];

    function automatic int mfind(bit [19:0] vpn, bit [7:0] asid);
        for (int w = 0; w < 4; w++)
            if (mv[vpn[3:0]][w] && mt[vpn[3:0]][w] == vpn[19:4] &&
                (mg[vpn[3:0]][w] || ma[vpn[3:0]][w] == asid))
                return w;
        return -1;
    endfunction

    task automatic mupdate();
        int kill_w [16][4];
        if (rst) begin
            for (int s = 0; s < 16; s++) begin
                mrr[s] = 0;
                for (int w = 0; w < 4; w++) mv[s][w] = 0;
            end
            return;
        end
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++) begin
                kill_w[s][w] = 0;
                if (inv_valid && inv_cmd == 2'b00) kill_w[s][w] = 1;
                if (inv_valid && inv_cmd == 2'b01 && !mg[s][w] && ma[s][w] == inv_asid)
                    kill_w[s][w] = 1;
                if (ctx_switch && !tag_en && !mg[s][w]) kill_w[s][w] = 1;
            end
        if (inv_valid && inv_cmd == 2'b10)
            for (int w = 0; w < 4; w++) begin
                int s = int'(inv_vpn[3:0]);
                if (mv[s][w] && mt[s][w] == inv_vpn[19:4] &&
                    (mg[s][w] || ma[s][w] == inv_asid))
                    kill_w[s][w] = 1;
            end
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                if (kill_w[s][w] != 0) mv[s][w] = 0;
        if (fill_valid && !inv_valid && !(ctx_switch && !tag_en)) begin
            int s = int'(fill_vpn[3:0]);
            int v = -1;
            for (int w = 0; w < 4; w++)
                if (v < 0 && mv[s][w] && mt[s][w] == fill_vpn[19:4] &&
                    (mg[s][w] || ma[s][w] == fill_asid))
                    v = w;
            if (v < 0)
                for (int w = 0; w < 4; w++)
                    if (v < 0 && !mv[s][w]) v = w;
            if (v < 0) begin
                v = mrr[s];
                mrr[s] = (mrr[s] + 1) % 4;
            end
            mv[s][v] = 1; mg[s][v] = fill_global; ma[s][v] = fill_asid;
            mt[s][v] = fill_vpn[19:4]; mp[s][v] = fill_pfn; mq[s][v] = fill_perm;
        end
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        mupdate();
        @(negedge clk);
    endtask

    // compare lookup port against the model, then advance one cycle
    task automatic cyc();
        #1;
        if (lk_valid) begin
            int w = mfind(lk_vpn, lk_asid);
            chk(lk_hit == (w >= 0) && lk_walk == (w < 0), "R1 R3 R4 model hit/walk",
                {lk_hit, lk_walk}, {w >= 0, w < 0});
            if (w >= 0) begin
                int s = int'(lk_vpn[3:0]);
                chk(lk_pfn == mp[s][w] && lk_perm == mq[s][w] && lk_global == mg[s][w],
                    "R1 model fields", {lk_global, lk_perm, lk_pfn}, {mg[s][w], mq[s][w], mp[s][w]});
            end
        end
        tick();
    endtask

    task automatic idle();
        lk_valid = 0; fill_valid = 0; inv_valid = 0; ctx_switch = 0;
    endtask

    task automatic fill(bit [19:0] vpn, bit [7:0] asid, bit [19:0] pfn, bit g);
        fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
        fill_perm = pfn[3:0]; fill_global = g;
        cyc();
        idle();
    endtask

    task automatic inv(bit [1:0] cmd, bit [19:0] vpn, bit [7:0] asid);
        inv_valid = 1; inv_cmd = cmd; inv_vpn = vpn; inv_asid = asid;
        cyc();
        idle();
    endtask

    task automatic ctx(bit ten);
        ctx_switch = 1; tag_en = ten;
        cyc();
        idle();
        tag_en = 1;
    endtask

    // directed lookup with explicit expectation; other inputs as already set
    task automatic look(bit [19:0] vpn, bit [7:0] asid, bit eh, bit [19:0] ep, string tag);
        lk_valid = 1; lk_vpn = vpn; lk_asid = asid;
        #1;
        chk(lk_hit == eh && lk_walk == !eh, tag, {lk_hit, lk_walk}, {eh, !eh});
        if (eh) chk(lk_pfn == ep, tag, lk_pfn, ep);
        tick();
        idle();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1;
        repeat (3) @(posedge clk);
        mupdate();
        @(negedge clk);
        rst = 0;

        // R12: empty after reset
        look(20'h00013, 8'd1, 0, 0, "R12 reset miss");
        look(20'h000F0, 8'd0, 0, 0, "R12 reset miss other set");

        // R1 / R3
        fill(20'h00013, 8'd1, 20'hAAAA1, 0);
        look(20'h00013, 8'd1, 1, 20'hAAAA1, "R1 hit after fill");
        look(20'h00013, 8'd2, 0, 0, "R3 other asid misses");

        // R4
        fill(20'h00025, 8'd1, 20'hBBBB2, 1);
        look(20'h00025, 8'd7, 1, 20'hBBBB2, "R4 global any asid");

        // R11 same-cycle lookup sees old, R5 per-space flush
        inv_valid = 1; inv_cmd = 2'b01; inv_asid = 8'd1;
        look(20'h00013, 8'd1, 1, 20'hAAAA1, "R11 lookup during invalidate sees old");
        look(20'h00013, 8'd1, 0, 0, "R5 space entry removed");
        look(20'h00025, 8'd1, 1, 20'hBBBB2, "R5 global survives");

        // R6
        fill(20'h00013, 8'd1, 20'hAAAA3, 0);
        ctx(1);
        look(20'h00013, 8'd1, 1, 20'hAAAA3, "R6 tagged switch keeps");
        ctx(0);
        look(20'h00013, 8'd1, 0, 0, "R6 untagged switch flushes");
        look(20'h00025, 8'd3, 1, 20'hBBBB2, "R6 global survives switch");

        // R7
        fill(20'h00044, 8'd2, 20'h44002, 0);
        fill(20'h00054, 8'd2, 20'h54002, 0);
        fill(20'h00044, 8'd3, 20'h44003, 0);
        inv(2'b10, 20'h00044, 8'd2);
        look(20'h00044, 8'd2, 0, 0, "R7 page removed");
        look(20'h00044, 8'd3, 1, 20'h44003, "R7 other asid kept");
        look(20'h00054, 8'd2, 1, 20'h54002, "R7 other page kept");

        // R10 / R9
        fill(20'h00044, 8'd3, 20'h77777, 0);
        look(20'h00044, 8'd3, 1, 20'h77777, "R10 overwrite in place");
        fill(20'h00064, 8'd3, 20'h64003, 0);
        fill(20'h00074, 8'd3, 20'h74003, 0);
        fill(20'h00084, 8'd3, 20'h84003, 0);
        look(20'h00064, 8'd3, 0, 0, "R9 rr evicts way0");
        look(20'h00044, 8'd3, 1, 20'h77777, "R10 no duplicate");
        look(20'h00084, 8'd3, 1, 20'h84003, "R9 new entry present");
        fill(20'h00094, 8'd3, 20'h94003, 0);
        look(20'h00054, 8'd2, 0, 0, "R9 rr evicts way1 next");
        look(20'h00074, 8'd3, 1, 20'h74003, "R9 way3 kept");

        // R2
        fill(20'h0000A, 8'd0, 20'h0A0A0, 0);
        for (int t = 1; t <= 5; t++) fill(20'(t * 16 + 9), 8'd0, 20'(t), 0);
        look(20'h0000A, 8'd0, 1, 20'h0A0A0, "R2 other set untouched");
        look(20'h00019, 8'd0, 0, 0, "R2 fifth fill evicts in set");
        look(20'h00059, 8'd0, 1, 20'd5, "R2 fifth entry present");

        // R11 dropped fill
        fill_valid = 1; fill_vpn = 20'h000B7; fill_asid = 8'd1; fill_pfn = 20'h0B7B7;
        fill_global = 0;
        inv_valid = 1; inv_cmd = 2'b11; inv_vpn = 20'h00001;
        tick(); idle();
        look(20'h000B7, 8'd1, 0, 0, "R11 fill dropped during invalidate");
        look(20'h00059, 8'd0, 1, 20'd5, "R8 code 11 removes nothing");

        // R8
        inv(2'b00, 20'h0, 8'd0);
        look(20'h00025, 8'd1, 0, 0, "R8 flush all removes global");

        // random traffic against model
        for (int i = 0; i < 4000; i++) begin
            int op = int'($urandom % 10);
            bit [3:0] t = 4'($urandom % 8);
            bit [3:0] s = 4'($urandom % 4);
            lk_valid = ($urandom % 8) != 0;
            lk_vpn = {12'h0, 4'($urandom % 8), 4'($urandom % 4)};
            lk_asid = 8'($urandom % 4);
            if (op < 5) begin
                fill_valid = 1; fill_vpn = {12'h0, t, s}; fill_asid = 8'($urandom % 4);
                fill_pfn = 20'($urandom); fill_perm = 4'($urandom); fill_global = (t >= 6);
            end
            if (op == 5 || (op == 0 && ($urandom % 4) == 0)) begin
                inv_valid = 1; inv_cmd = 2'($urandom);
                if (inv_cmd == 2'b00 && ($urandom % 4) != 0) inv_cmd = 2'b10;
                inv_vpn = {12'h0, 4'($urandom % 8), 4'($urandom % 4)};
                inv_asid = 8'($urandom % 4);
            end
            if (op == 6 && ($urandom % 3) == 0) begin
                ctx_switch = 1; tag_en = $urandom % 2;
            end
            cyc();
            idle();
            tag_en = 1;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule